// File: doc/BRIEF.md
# Programmable Clock Burst Counter

This block produces a software-requested number of single-cycle clock-enable pulses. Writing a value to the count register launches a burst: the block raises its pulse output once every `PERIOD` cycles until it has emitted exactly that many pulses. A downstream clock gate or pin driver uses the pulse output to clock out trailing configuration clocks, typically a small count such as 4 once the configuration stream has ended.

Completion is reported through a sticky done flag in the status register. The flag stays set until software writes a 1 to it. Software usually clears the flag, writes the count, polls the status register until it reads exactly 1, and then clears the flag again. The count register reads back the number of pulses still to be emitted, so a burst's progress can be observed.

Top module: `cfg_clk_burst`

## Requirements
- R1: After reset the pulse output is low, the count register (offset 0x8) reads 0 and the status register (offset 0xC) reads 0.
- R2: A write to offset 0x8 loads bits [CNT_W-1:0] of the write data as the count N, and higher bits are ignored. For N > 0 the block then emits exactly N single-cycle pulses on `pulse_en`. The first pulse is high in the cycle after the write edge, and successive pulses start PERIOD cycles apart.
- R3: The done flag is status bit 0 and is set at the clock edge that ends the last pulse. While done is set the status register reads exactly 0x00000001; otherwise it reads 0.
- R4: The done flag stays set until a write to offset 0xC with data bit 0 = 1 clears it. A status write with bit 0 = 0 leaves it unchanged.
- R5: A count write of 0 emits no pulse, ends any running burst, and sets done at the write edge.
- R6: A nonzero count write during a burst restarts the burst with the new count. Any nonzero count write clears done at the write edge.
- R7: If the final pulse of a burst and a clearing status write occur in the same cycle, done ends up set.
- R8: Reading offset 0x8 returns the remaining pulse count. The value decrements by one at the edge that ends each pulse.
- R9: Other offsets read as 0, and writes to them change neither the count nor the done flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pulse_en | output | 1 | Single-cycle clock-enable pulse |

## Verification
The bench builds the block with CNT_W = 4 and PERIOD = 2. The 4-bit count puts the full-scale burst of 15 pulses within a short run, and a write of 0x13 or 0xFFFFFFF0 exercises truncation of the count to its field, including truncation to zero. PERIOD = 2 keeps pulse spacing and the done cycle, at (N-1)*2+1 cycles after the write, distinct from a pulse on every cycle. With this period, a restart in mid-burst and a set-versus-clear collision on the final pulse fall at cycles the bench can compute exactly.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Byte offsets; software depends on these locations.
  localparam int unsigned OFS_COUNT  = 32'h8;
  localparam int unsigned OFS_STATUS = 32'hC;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_STATUS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
  import burst_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_COUNT)) begin
      sel = SEL_COUNT;
    end else if (addr == ADDR_W'(OFS_STATUS)) begin
      sel = SEL_STATUS;
    end else begin
      sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/burst_pulse_counter.sv
module burst_pulse_counter #(
  parameter int CNT_W  = 16,
  parameter int PERIOD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remaining,
  output logic             pulse,
  output logic             finish
);
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic [PH_W-1:0]  ph_q;
  logic             ph_zero;

  generate
    if (PERIOD > 1) begin : g_spaced
      logic [PH_W-1:0] ph_d;
      always_comb begin
        ph_d = ph_q;
        if (load_en) begin
          ph_d = '0;
        end else if (rem_q != '0) begin
          ph_d = (ph_q == '0) ? PH_LAST : ph_q - PH_W'(1);
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ph_q <= '0;
        end else begin
          ph_q <= ph_d;
        end
      end
    end else begin : g_back_to_back
      assign ph_q = '0;
    end
  endgenerate

  assign ph_zero = (ph_q == '0);
  assign pulse   = (rem_q != '0) && ph_zero;
  assign finish  = pulse && (rem_q == CNT_W'(1)) && !load_en;

  always_comb begin
    rem_d = rem_q;
    if (load_en) begin
      rem_d = load_val;
    end else if (pulse) begin
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_d;
    end
  end

  assign remaining = rem_q;
endmodule

// File: rtl/burst_done_flag.sv
module burst_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic done
);
  logic done_q, done_d;

  // Set has priority over clear.
  always_comb begin
    done_d = done_q;
    if (set_i) begin
      done_d = 1'b1;
    end else if (clr_i) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/cfg_clk_burst.sv
module cfg_clk_burst
  import burst_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PERIOD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pulse_en
);
  reg_sel_e         sel;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic             load_zero;
  logic             w1c;
  logic [CNT_W-1:0] remaining_q;
  logic             finish;
  logic             done_q;
  logic             unused_wdata;

  burst_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign load_en      = bus_wr && (sel == SEL_COUNT);
  assign load_val     = bus_wdata[CNT_W-1:0];
  assign load_zero    = load_en && (load_val == '0);
  assign w1c          = bus_wr && (sel == SEL_STATUS) && bus_wdata[0];
  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  burst_pulse_counter #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_val  (load_val),
    .remaining (remaining_q),
    .pulse     (pulse_en),
    .finish    (finish)
  );

  burst_done_flag u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (finish || load_zero),
    .clr_i (w1c || (load_en && !load_zero)),
    .done  (done_q)
  );

  always_comb begin
    unique case (sel)
      SEL_COUNT:  bus_rdata = DATA_W'(remaining_q);
      SEL_STATUS: bus_rdata = DATA_W'(done_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/burst_checker.sv
module burst_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pulse_en,
  input logic [CNT_W-1:0] remaining,
  input logic             done,
  input logic             load_en,
  input logic [CNT_W-1:0] load_val,
  input logic             w1c
);
  logic last_pulse;
  assign last_pulse = pulse_en && (remaining == CNT_W'(1)) && !load_en;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining == '0) |-> !pulse_en);

  assert_pulse_consumes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_en && !load_en) |=> (remaining == $past(remaining) - CNT_W'(1)));

  assert_last_pulse_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_pulse |=> done);

  assert_clear_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !load_en && !last_pulse) |=> !done);

  assert_sticky_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!w1c && !load_en && !last_pulse) |=> (done == $past(done)));

  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && (load_val == '0)) |=> (done && (remaining == '0)));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && (load_val != '0)) |=> (!done && (remaining == $past(load_val))));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_pulse && w1c) |=> done);
endmodule

bind cfg_clk_burst burst_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pulse_en  (pulse_en),
  .remaining (remaining_q),
  .done      (done_q),
  .load_en   (load_en),
  .load_val  (load_val),
  .w1c       (w1c)
);

// File: tb/tb_cfg_clk_burst.sv
module tb_cfg_clk_burst;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int PERIOD = 2;
  localparam logic [ADDR_W-1:0] A_CNT  = 12'h008;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] A_OTH  = 12'h004;

  // {write data, expected pulses, expected cycles to done}; cycles = (N-1)*PERIOD+1, or 0 for N=0
  localparam int NVEC = 7;
  localparam logic [55:0] VEC [0:NVEC-1] = '{
    {32'h0000_0001, 8'd1,  16'd1},
    {32'h0000_0004, 8'd4,  16'd7},
    {32'h0000_000F, 8'd15, 16'd29},
    {32'h0000_0013, 8'd3,  16'd5},
    {32'h0000_0000, 8'd0,  16'd0},
    {32'h0000_0002, 8'd2,  16'd3},
    {32'hFFFF_FFF0, 8'd0,  16'd0}
  };

  logic              clk;
  logic              rst_n;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              pulse_en;

  int errors = 0;
  int checks = 0;

  cfg_clk_burst #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PERIOD(PERIOD)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pulse_en  (pulse_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge.
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic read_reg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic run_burst(output int pulses, output int k);
    logic [DATA_W-1:0] st;
    pulses = 0;
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      read_reg(A_STAT, st);
      if (st != 0) break;
      if (pulse_en) pulses++;
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    logic [DATA_W-1:0] rd;
    int np;
    int nk;
    bus_wr = 1'b0;
    bus_addr = A_STAT;
    bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pulse_en == 1'b0, "R1 pulse after reset", pulse_en, 0);
    read_reg(A_CNT, rd);
    check(rd == 0, "R1 count after reset", rd, 0);
    read_reg(A_STAT, rd);
    check(rd == 0, "R1 status after reset", rd, 0);

    // Vector table: R2 pulse count/spacing, R3 done timing and value, R5 zero count
    for (int v = 0; v < NVEC; v++) begin
      bus_write(A_CNT, VEC[v][55:24]);
      run_burst(np, nk);
      check(np == int'(VEC[v][23:16]), $sformatf("R2 pulses vec%0d", v), np, VEC[v][23:16]);
      check(nk == int'(VEC[v][15:0]), $sformatf("R3 done cycle vec%0d", v), nk, VEC[v][15:0]);
      read_reg(A_STAT, rd);
      check(rd == 32'h1, $sformatf("R3 status value vec%0d", v), rd, 1);
      bus_write(A_STAT, 32'h1);
      read_reg(A_STAT, rd);
      check(rd == 0, $sformatf("R4 cleared vec%0d", v), rd, 0);
    end

    // R2 spacing: pulse, gap, pulse
    bus_write(A_CNT, 32'h3);
    check(pulse_en == 1'b1, "R2 first pulse", pulse_en, 1);
    @(negedge clk);
    check(pulse_en == 1'b0, "R2 gap cycle", pulse_en, 0);
    // R8 remaining count readback
    read_reg(A_CNT, rd);
    check(rd == 2, "R8 remaining after one pulse", rd, 2);
    @(negedge clk);
    check(pulse_en == 1'b1, "R2 second pulse", pulse_en, 1);
    @(negedge clk);
    read_reg(A_CNT, rd);
    check(rd == 1, "R8 remaining after two pulses", rd, 1);
    run_burst(np, nk);
    read_reg(A_CNT, rd);
    check(rd == 0, "R8 remaining at done", rd, 0);

    // R4 sticky: status write of 0 leaves done set
    bus_write(A_STAT, 32'hFFFF_FFFE);
    read_reg(A_STAT, rd);
    check(rd == 32'h1, "R4 write 0 keeps done", rd, 1);
    // R9 other offset ignored and reads 0
    bus_write(A_OTH, 32'hFFFF_FFFF);
    read_reg(A_STAT, rd);
    check(rd == 32'h1, "R9 other write keeps done", rd, 1);
    read_reg(A_CNT, rd);
    check(rd == 0, "R9 other write keeps count", rd, 0);
    read_reg(A_OTH, rd);
    check(rd == 0, "R9 other offset reads 0", rd, 0);
    bus_write(A_STAT, 32'h1);

    // R5 zero write aborts a running burst
    bus_write(A_CNT, 32'h9);
    @(negedge clk);
    bus_write(A_CNT, 32'h0);
    read_reg(A_STAT, rd);
    check(rd == 32'h1, "R5 zero sets done", rd, 1);
    read_reg(A_CNT, rd);
    check(rd == 0, "R5 zero aborts count", rd, 0);
    np = 0;
    for (int i = 0; i < 6; i++) begin
      if (pulse_en) np++;
      @(negedge clk);
    end
    check(np == 0, "R5 no pulses after zero", np, 0);

    // R6 nonzero write clears done
    bus_write(A_CNT, 32'h3);
    read_reg(A_STAT, rd);
    check(rd == 0, "R6 load clears done", rd, 0);
    run_burst(np, nk);
    bus_write(A_STAT, 32'h1);

    // R6 restart mid-burst
    bus_write(A_CNT, 32'h6);
    @(negedge clk);
    @(negedge clk);
    bus_write(A_CNT, 32'h2);
    run_burst(np, nk);
    check(np == 2, "R6 restart pulse count", np, 2);
    check(nk == 3, "R6 restart done cycle", nk, 3);
    bus_write(A_STAT, 32'h1);

    // R7 set wins over same-cycle clear
    bus_write(A_CNT, 32'h1);
    bus_write(A_STAT, 32'h1);
    read_reg(A_STAT, rd);
    check(rd == 32'h1, "R7 set wins", rd, 1);
    bus_write(A_STAT, 32'h1);
    read_reg(A_STAT, rd);
    check(rd == 0, "R4 clear after collision", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule